// File: doc/BRIEF.md
# Memory Slot Arbiter with Blitter Yield

The block decides, once per memory access slot, which of four requesters may use the shared memory. In falling order of priority the requesters are: the display fetch (which also stands in for the fixed per-line disk, sprite and refresh uses), the display-list coprocessor, the blitter and the CPU. A one-cycle slot strobe marks each slot boundary. The arbiter samples the requests on the strobe and registers a one-hot grant. That grant holds until the next strobe.

Under plain fixed priority, a busy blitter would keep the CPU out of memory for as long as it kept requesting. To prevent this, a blitter-priority control bit selects between two modes. With the bit set, the blitter keeps every slot it wins. With the bit clear, a counter tracks consecutive blitter grants, and every fourth slot the blitter would otherwise win is handed back. That returned slot goes to the CPU if the CPU is requesting; otherwise it stays idle. The yield period is a parameter.

Top module: `slot_arbiter`

## Requirements
- R1: While reset is high and in the cycle after it, `grant` is 4'b0000. Grant bit 0 is display, bit 1 is coprocessor, bit 2 is blitter and bit 3 is CPU.
- R2: A display request at a strobe gives grant 4'b0001 for that slot, whatever the other requests are.
- R3: The coprocessor wins (4'b0010) over the blitter and the CPU when the display is not requesting.
- R4: The blitter wins (4'b0100) over the CPU when neither higher requester asks and no yield is due.
- R5: When only the CPU requests, it gets 4'b1000. With no requests the grant is 4'b0000.
- R6: At most one grant bit is set in any cycle.
- R7: `grant` changes only in the cycle after a strobe and is held unchanged between strobes.
- R8: With `blit_prio` low and the blitter requesting continuously, each run of three blitter grants is followed by a yielded slot. A yielded slot goes to the CPU if the CPU is requesting.
- R9: A yielded slot with no CPU request is left idle (4'b0000).
- R10: With `blit_prio` high, the blitter never yields. It wins every slot that no higher requester takes.
- R11: The run count resets when a strobe finds the blitter not requesting. A slot taken by the display or the coprocessor while the blitter waits neither advances the count nor clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_stb | input | 1 | One-cycle pulse marking a slot boundary |
| req_disp | input | 1 | Display/fixed-channel fetch request |
| req_cop | input | 1 | Coprocessor request |
| req_blit | input | 1 | Blitter request |
| req_cpu | input | 1 | CPU request |
| blit_prio | input | 1 | 1: blitter never yields; 0: blitter yields periodically |
| grant | output | 4 | One-hot grant for the current slot |

## Verification
Two things can fall due on the same strobe: the blitter's periodic yield and a higher-priority request. The bench provokes this in two steps. It first lets the blitter collect three grants. It then raises the display request on the strobe where the yield is due, which must go to the display. The bench then checks that the yield is still pending and is taken on the next blitter-only slot. A second case lets the blitter's request drop exactly at the yield point, with the CPU requesting. The CPU must get that slot, and the blitter's next run must again start a full count of three.

// File: rtl/slot_arbiter_pkg.sv
package slot_arbiter_pkg;
  localparam int NUM_REQ = 4;
  // requester index doubles as priority rank (0 = highest)
  typedef enum logic [1:0] {
    RQ_DISP = 2'd0,
    RQ_COP  = 2'd1,
    RQ_BLIT = 2'd2,
    RQ_CPU  = 2'd3
  } req_idx_e;
endpackage

// File: rtl/slot_prio_pick.sv
module slot_prio_pick
  import slot_arbiter_pkg::*;
#(
  parameter int N = NUM_REQ
) (
  input  logic [N-1:0] req,
  input  logic         yield_due,
  output logic [N-1:0] pick,
  output logic         blit_win,
  output logic         yield_take
);
  logic [N-1:0] eff;
  logic         found;

  always_comb begin
    eff = req;
    yield_take = yield_due && req[RQ_BLIT] && !req[RQ_DISP] && !req[RQ_COP];
    if (yield_due) eff[RQ_BLIT] = 1'b0;
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (eff[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
    blit_win = pick[RQ_BLIT];
  end
endmodule

// File: rtl/blit_yield_ctr.sv
module blit_yield_ctr #(
  parameter int YIELD_PERIOD = 4,
  localparam int CW = (YIELD_PERIOD > 2) ? $clog2(YIELD_PERIOD) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic slot_stb,
  input  logic req_blit,
  input  logic blit_prio,
  input  logic blit_win,
  input  logic yield_take,
  output logic yield_due
);
  localparam logic [CW-1:0] LAST = CW'(YIELD_PERIOD - 1);
  logic [CW-1:0] run_q;

  assign yield_due = !blit_prio && (run_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (slot_stb) begin
      if (!req_blit || yield_take || blit_prio) run_q <= '0;
      else if (blit_win) run_q <= run_q + 1'b1;
    end
  end

  // R8
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q <= LAST);

  // R11
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && !req_blit) |=> (run_q == '0));
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arbiter_pkg::*;
#(
  parameter int YIELD_PERIOD = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       slot_stb,
  input  logic       req_disp,
  input  logic       req_cop,
  input  logic       req_blit,
  input  logic       req_cpu,
  input  logic       blit_prio,
  output logic [3:0] grant
);
  logic [NUM_REQ-1:0] req_vec;
  logic [NUM_REQ-1:0] pick;
  logic               blit_win;
  logic               yield_take;
  logic               yield_due;

  assign req_vec = {req_cpu, req_blit, req_cop, req_disp};

  slot_prio_pick #(.N(NUM_REQ)) u_pick (
    .req        (req_vec),
    .yield_due  (yield_due),
    .pick       (pick),
    .blit_win   (blit_win),
    .yield_take (yield_take)
  );

  blit_yield_ctr #(.YIELD_PERIOD(YIELD_PERIOD)) u_ctr (
    .clk        (clk),
    .rst        (rst),
    .slot_stb   (slot_stb),
    .req_blit   (req_blit),
    .blit_prio  (blit_prio),
    .blit_win   (blit_win),
    .yield_take (yield_take),
    .yield_due  (yield_due)
  );

  always_ff @(posedge clk) begin
    if (rst)           grant <= '0;
    else if (slot_stb) grant <= pick;
  end

  // R6
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_stb |=> $stable(grant));

  // R2
  disp_first_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && req_disp) |=> (grant == 4'b0001));

  // R10
  prio_no_yield_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && blit_prio && req_blit && !req_disp && !req_cop)
      |=> (grant == 4'b0100));

  // R5
  no_req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_stb && !req_disp && !req_cop && !req_blit && !req_cpu)
      |=> (grant == 4'b0000));
endmodule

// File: tb/slot_arbiter_tb.sv
module slot_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] G_D = 4'b0001, G_C = 4'b0010, G_B = 4'b0100,
                         G_P = 4'b1000, G_0 = 4'b0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_stb = 1'b0;
  logic req_disp = 1'b0, req_cop = 1'b0, req_blit = 1'b0, req_cpu = 1'b0;
  logic blit_prio = 1'b0;
  logic [3:0] grant;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_arbiter u_dut (
    .clk(clk), .rst(rst), .slot_stb(slot_stb),
    .req_disp(req_disp), .req_cop(req_cop), .req_blit(req_blit),
    .req_cpu(req_cpu), .blit_prio(blit_prio), .grant(grant)
  );

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: grant=%b expected=%b", tag, got, exp);
    end
  endtask

  // one slot: requests {disp,cop,blit,cpu}; grant checked after the edge
  task automatic slot(input logic [3:0] r, input logic [3:0] exp, input string tag);
    @(negedge clk);
    {req_disp, req_cop, req_blit, req_cpu} = r;
    slot_stb = 1'b1;
    @(negedge clk);
    slot_stb = 1'b0;
    check(tag, grant, exp);
  endtask

  task automatic clear_run();
    slot(4'b0000, G_0, "R5 idle slot");
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 in reset", grant, G_0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", grant, G_0);
  endtask

  task automatic t_priority();
    blit_prio = 1'b0;
    clear_run();
    slot(4'b1111, G_D, "R2 all request");
    slot(4'b1000, G_D, "R2 display only");
    slot(4'b0111, G_C, "R3 cop over blit/cpu");
    slot(4'b0101, G_C, "R3 cop over cpu");
    clear_run();
    slot(4'b0011, G_B, "R4 blit over cpu");
    slot(4'b0001, G_P, "R5 cpu only");
    slot(4'b0000, G_0, "R5 none");
  endtask

  task automatic t_hold();
    slot(4'b0001, G_P, "R7 cpu granted");
    @(negedge clk);
    {req_disp, req_cop, req_blit, req_cpu} = 4'b1100;
    repeat (3) begin
      @(negedge clk);
      check("R7 held between strobes", grant, G_P);
    end
    slot(4'b0100, G_C, "R7 next strobe re-evaluates");
  endtask

  task automatic t_yield_cpu();
    blit_prio = 1'b0;
    clear_run();
    for (int k = 0; k < 2; k++) begin
      slot(4'b0011, G_B, "R8 blit run 1");
      slot(4'b0011, G_B, "R8 blit run 2");
      slot(4'b0011, G_B, "R8 blit run 3");
      slot(4'b0011, G_P, "R8 yield to cpu");
    end
    slot(4'b0011, G_B, "R8 blit resumes");
  endtask

  task automatic t_yield_idle();
    clear_run();
    slot(4'b0010, G_B, "R9 run 1");
    slot(4'b0010, G_B, "R9 run 2");
    slot(4'b0010, G_B, "R9 run 3");
    slot(4'b0010, G_0, "R9 yielded slot idle");
    slot(4'b0010, G_B, "R9 blit after idle");
  endtask

  task automatic t_prio_mode();
    blit_prio = 1'b1;
    clear_run();
    for (int k = 0; k < 9; k++) slot(4'b0011, G_B, "R10 no yield");
    blit_prio = 1'b0;
  endtask

  task automatic t_counter();
    clear_run();
    // display arrives exactly when the yield is due; the yield waits
    slot(4'b0011, G_B, "R11 run 1");
    slot(4'b0011, G_B, "R11 run 2");
    slot(4'b1011, G_D, "R11 display interposes");
    slot(4'b0011, G_B, "R11 run 3 after display");
    slot(4'b1011, G_D, "R11 display on due yield");
    slot(4'b0011, G_P, "R11 pending yield taken");
    // blitter drops at the yield point: cpu wins, count restarts
    slot(4'b0011, G_B, "R11 run 1b");
    slot(4'b0011, G_B, "R11 run 2b");
    slot(4'b0011, G_B, "R11 run 3b");
    slot(4'b0001, G_P, "R11 blit drops");
    slot(4'b0011, G_B, "R11 fresh run 1");
    slot(4'b0011, G_B, "R11 fresh run 2");
    slot(4'b0011, G_B, "R11 fresh run 3");
    slot(4'b0011, G_P, "R11 fresh yield");
  endtask

  initial begin
    t_reset();
    t_priority();
    t_hold();
    t_yield_cpu();
    t_yield_idle();
    t_prio_mode();
    t_counter();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule